// File: doc/BRIEF.md
# MSI Event Ring Poster

This block collects inbound message-signalled interrupt words and turns each one into a 16-byte record written into a circular buffer in host memory. Software sets up the ring through a small register file: a control word, a 64-bit base address and a read offset. The block keeps its own write offset, which advances by one record for every entry that memory accepts. It wraps at a ring size that software picks as a power of two between 32 KB and 256 KB.

Records leave through a single-beat memory write port with a valid/ready handshake. The port carries the full 64-bit byte address (base plus write offset) and the 128-bit record. A two-state machine does the posting. In `ST_IDLE` it offers `msi_ready`, and the **accept** transition (`ST_IDLE` to `ST_ISSUE`) fires when an MSI word is taken. In `ST_ISSUE` it holds the memory request, and the **retire** transition (`ST_ISSUE` to `ST_IDLE`) fires on `mem_ready`, which also advances the write offset. In every other case the machine holds its state. A level interrupt tells the host that unread records exist. Software can choose to stall incoming MSIs when the ring is full instead of overwriting unread records.

Top module: `msi_ring_poster`

## Requirements
- R1: After reset every register reads zero, and `msi_ready`, `mem_valid` and `irq_out` are low.
- R2: Registers are selected by `reg_addr`: 0 control, 3 base address bits 63:32, 4 base address bits 31:0, 5 read offset, 6 write offset (read-only). Any other address reads zero. Control bits are: 0 enable, 1 full detection, 3 interrupt enable, 4 stop-on-full, 9:8 size code. All other control bits read back zero.
- R3: Each accepted MSI produces exactly one memory request. The address is base + write offset. Data bits 15:0 hold the MSI word's low 16 bits, and data bits 127:16 are zero. Address and data stay stable while `mem_valid` is high and `mem_ready` is low.
- R4: The write offset changes only when a request is retired. It then advances by 16 and wraps modulo the ring size, which is 2^(15+code) bytes.
- R5: A value written to the read offset is stored ANDed with (size-1), with bits 3:0 cleared.
- R6: While enable (control bit 0) is clear, `msi_ready` stays low and no memory request is issued.
- R7: The ring is full when (write offset + 16) mod size equals the read offset. When full, with control bits 0, 1 and 4 all set, `msi_ready` is low. Without stop-on-full, posting continues and the write offset may reach the read offset.
- R8: `irq_out` is high exactly when control bits 0 and 3 are set and the read offset differs from the write offset.
- R9: Both offsets are read back, compared and used under the size mask currently in force. A smaller size code therefore masks a previously stored offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| msi_valid | input | 1 | Inbound MSI word present |
| msi_data | input | 32 | Inbound MSI word |
| msi_ready | output | 1 | MSI word accepted this cycle |
| mem_valid | output | 1 | Record write request |
| mem_ready | input | 1 | Memory takes the record |
| mem_addr | output | 64 | Record byte address |
| mem_data | output | 128 | Record contents |
| irq_out | output | 1 | Level interrupt to host |

## Verification
The retire of a pending record and a software write of the read offset can land on the same clock edge. That edge moves both offsets, and the interrupt and full state then depend on both new values. The bench stalls the memory port with a record pending. It then raises `mem_ready` in the same cycle as the read-offset write, choosing a value equal to the write offset that will result. It judges the outcome by reading back both offsets and by requiring that the interrupt drops and exactly one handshake was counted.

// File: rtl/msi_ring_pkg.sv
package msi_ring_pkg;

    // Register word addresses (software decodes these)
    localparam logic [2:0] RA_CTRL    = 3'h0;
    localparam logic [2:0] RA_BASE_HI = 3'h3;
    localparam logic [2:0] RA_BASE_LO = 3'h4;
    localparam logic [2:0] RA_RD_OFF  = 3'h5;
    localparam logic [2:0] RA_WR_OFF  = 3'h6;

    // Control bit positions
    localparam int CB_EN       = 0;
    localparam int CB_FULL_DET = 1;
    localparam int CB_IRQ_EN   = 3;
    localparam int CB_STOP     = 4;
    localparam int CB_SIZE_LO  = 8;

    // Geometry
    localparam int REG_DW      = 32;
    localparam int BASE_W      = 64;
    localparam int SIZE_CODE_W = 2;
    localparam int MIN_LOG     = 15;
    localparam int ENTRY_LOG   = 4;
    localparam int MSI_W       = 16;
    localparam int OFF_W       = MIN_LOG + (1 << SIZE_CODE_W) - 1;
    localparam int ENTRY_BYTES = 1 << ENTRY_LOG;
    localparam int ENTRY_W     = 8 * ENTRY_BYTES;

    typedef struct packed {
        logic [SIZE_CODE_W-1:0] size_code;
        logic                   stop_on_full;
        logic                   irq_en;
        logic                   full_det;
        logic                   enable;
    } ctrl_t;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } post_state_t;

endpackage

// File: rtl/msi_ring_mask.sv
module msi_ring_mask #(
    parameter int OFF_W       = msi_ring_pkg::OFF_W,
    parameter int MIN_LOG     = msi_ring_pkg::MIN_LOG,
    parameter int ENTRY_LOG   = msi_ring_pkg::ENTRY_LOG,
    parameter int SIZE_CODE_W = msi_ring_pkg::SIZE_CODE_W
) (
    input  logic [SIZE_CODE_W-1:0] size_code,
    output logic [OFF_W-1:0]       size_mask
);

    // One bit per offset position: below the entry granule is always zero,
    // below the smallest ring is always one, the rest depends on the code.
    for (genvar i = 0; i < OFF_W; i++) begin : g_bit
        if (i < ENTRY_LOG) begin : g_low
            assign size_mask[i] = 1'b0;
        end else if (i < MIN_LOG) begin : g_fixed
            assign size_mask[i] = 1'b1;
        end else begin : g_var
            localparam int NEED = i - MIN_LOG + 1;
            assign size_mask[i] = (size_code >= SIZE_CODE_W'(NEED));
        end
    end

endmodule

// File: rtl/msi_ring_regs.sv
module msi_ring_regs
    import msi_ring_pkg::*;
#(
    parameter int OFF_W     = msi_ring_pkg::OFF_W,
    parameter int ENTRY_LOG = msi_ring_pkg::ENTRY_LOG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic [OFF_W-1:0]  size_mask,
    input  logic [OFF_W-1:0]  wr_off,
    output ctrl_t             ctrl,
    output logic [BASE_W-1:0] base_addr,
    output logic [OFF_W-1:0]  rd_off
);

    ctrl_t             ctrl_q;
    logic [BASE_W-1:0] base_q;
    logic [OFF_W-1:0]  rd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            base_q <= '0;
            rd_q   <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                RA_CTRL: begin
                    ctrl_q.enable       <= reg_wdata[CB_EN];
                    ctrl_q.full_det     <= reg_wdata[CB_FULL_DET];
                    ctrl_q.irq_en       <= reg_wdata[CB_IRQ_EN];
                    ctrl_q.stop_on_full <= reg_wdata[CB_STOP];
                    ctrl_q.size_code    <= reg_wdata[CB_SIZE_LO +: SIZE_CODE_W];
                end
                RA_BASE_HI: base_q[BASE_W-1:REG_DW] <= reg_wdata;
                RA_BASE_LO: base_q[REG_DW-1:0]      <= reg_wdata;
                RA_RD_OFF:  rd_q <= reg_wdata[OFF_W-1:0] & size_mask;
                default: ;
            endcase
        end
    end

    assign ctrl      = ctrl_q;
    assign base_addr = base_q;
    assign rd_off    = rd_q & size_mask;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL: begin
                reg_rdata[CB_EN]                     = ctrl_q.enable;
                reg_rdata[CB_FULL_DET]               = ctrl_q.full_det;
                reg_rdata[CB_IRQ_EN]                 = ctrl_q.irq_en;
                reg_rdata[CB_STOP]                   = ctrl_q.stop_on_full;
                reg_rdata[CB_SIZE_LO +: SIZE_CODE_W] = ctrl_q.size_code;
            end
            RA_BASE_HI: reg_rdata = base_q[BASE_W-1:REG_DW];
            RA_BASE_LO: reg_rdata = base_q[REG_DW-1:0];
            RA_RD_OFF:  reg_rdata = {{(REG_DW-OFF_W){1'b0}}, rd_off};
            RA_WR_OFF:  reg_rdata = {{(REG_DW-OFF_W){1'b0}}, wr_off};
            default:    reg_rdata = '0;
        endcase
    end

    // R5
    rd_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_q[ENTRY_LOG-1:0] == '0);

endmodule

// File: rtl/msi_ring_wptr.sv
module msi_ring_wptr #(
    parameter int OFF_W     = msi_ring_pkg::OFF_W,
    parameter int ENTRY_LOG = msi_ring_pkg::ENTRY_LOG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic [OFF_W-1:0] size_mask,
    output logic [OFF_W-1:0] wr_off
);

    localparam int STEP = 1 << ENTRY_LOG;

    logic [OFF_W-1:0] wr_q;

    assign wr_off = wr_q & size_mask;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
        end else if (advance) begin
            wr_q <= (wr_off + OFF_W'(STEP)) & size_mask;
        end
    end

    // R4
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && $stable(size_mask)) |=> $stable(wr_off));

endmodule

// File: rtl/msi_ring_post_fsm.sv
module msi_ring_post_fsm
    import msi_ring_pkg::*;
#(
    parameter int ADDR_W  = msi_ring_pkg::BASE_W,
    parameter int ENTRY_W = msi_ring_pkg::ENTRY_W,
    parameter int NUM_W   = msi_ring_pkg::MSI_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               block,
    input  logic               msi_valid,
    input  logic [NUM_W-1:0]   msi_num,
    output logic               msi_ready,
    input  logic [ADDR_W-1:0]  slot_addr,
    output logic               mem_valid,
    input  logic               mem_ready,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [ENTRY_W-1:0] mem_data,
    output logic               advance
);

    post_state_t        state_q, state_d;
    logic [ADDR_W-1:0]  addr_q;
    logic [ENTRY_W-1:0] data_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: accept and retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (msi_valid && enable && !block) state_d = ST_ISSUE;
            ST_ISSUE: if (mem_ready) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        msi_ready = 1'b0;
        mem_valid = 1'b0;
        advance   = 1'b0;
        unique case (state_q)
            ST_IDLE:  msi_ready = enable && !block;
            ST_ISSUE: begin
                mem_valid = 1'b1;
                advance   = mem_ready;
            end
            default: ;
        endcase
    end

    // Record capture on accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (state_q == ST_IDLE && msi_valid && msi_ready) begin
            addr_q <= slot_addr;
            data_q <= {{(ENTRY_W-NUM_W){1'b0}}, msi_num};
        end
    end

    assign mem_addr = addr_q;
    assign mem_data = data_q;

    // R3
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    // R6
    ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msi_ready |-> enable);

endmodule

// File: rtl/msi_ring_poster.sv
module msi_ring_poster
    import msi_ring_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [2:0]          reg_addr,
    input  logic [REG_DW-1:0]   reg_wdata,
    output logic [REG_DW-1:0]   reg_rdata,
    input  logic                msi_valid,
    input  logic [REG_DW-1:0]   msi_data,
    output logic                msi_ready,
    output logic                mem_valid,
    input  logic                mem_ready,
    output logic [BASE_W-1:0]   mem_addr,
    output logic [ENTRY_W-1:0]  mem_data,
    output logic                irq_out
);

    ctrl_t             ctrl;
    logic [BASE_W-1:0] base_addr;
    logic [OFF_W-1:0]  size_mask;
    logic [OFF_W-1:0]  rd_off;
    logic [OFF_W-1:0]  wr_off;
    logic [OFF_W-1:0]  next_off;
    logic [BASE_W-1:0] slot_addr;
    logic              ring_full;
    logic              block;
    logic              advance;
    logic              unused_msi_hi;

    assign unused_msi_hi = ^msi_data[REG_DW-1:MSI_W];

    msi_ring_mask #(
        .OFF_W(OFF_W), .MIN_LOG(MIN_LOG), .ENTRY_LOG(ENTRY_LOG), .SIZE_CODE_W(SIZE_CODE_W)
    ) u_mask (
        .size_code (ctrl.size_code),
        .size_mask (size_mask)
    );

    msi_ring_regs #(.OFF_W(OFF_W), .ENTRY_LOG(ENTRY_LOG)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .size_mask (size_mask),
        .wr_off    (wr_off),
        .ctrl      (ctrl),
        .base_addr (base_addr),
        .rd_off    (rd_off)
    );

    msi_ring_wptr #(.OFF_W(OFF_W), .ENTRY_LOG(ENTRY_LOG)) u_wptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (advance),
        .size_mask (size_mask),
        .wr_off    (wr_off)
    );

    assign next_off  = (wr_off + OFF_W'(ENTRY_BYTES)) & size_mask;
    assign ring_full = (next_off == rd_off);
    assign block     = ctrl.full_det && ctrl.stop_on_full && ring_full;
    assign slot_addr = base_addr + {{(BASE_W-OFF_W){1'b0}}, wr_off};

    msi_ring_post_fsm #(.ADDR_W(BASE_W), .ENTRY_W(ENTRY_W), .NUM_W(MSI_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (ctrl.enable),
        .block     (block),
        .msi_valid (msi_valid),
        .msi_num   (msi_data[MSI_W-1:0]),
        .msi_ready (msi_ready),
        .slot_addr (slot_addr),
        .mem_valid (mem_valid),
        .mem_ready (mem_ready),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .advance   (advance)
    );

    assign irq_out = ctrl.enable && ctrl.irq_en && (rd_off != wr_off);

    // R7
    full_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.enable && ctrl.full_det && ctrl.stop_on_full && ring_full) |-> !msi_ready);

    // R8
    irq_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (rd_off != wr_off));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!mem_valid && !irq_out && !msi_ready));

endmodule

// File: tb/sim_msi_ring_poster.sv
`timescale 1ns/1ps
module sim_msi_ring_poster;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         msi_valid = 1'b0;
    logic [31:0]  msi_data = '0;
    logic         msi_ready;
    logic         mem_valid;
    logic         mem_ready = 1'b1;
    logic [63:0]  mem_addr;
    logic [127:0] mem_data;
    logic         irq_out;

    int n_chk = 0;
    int n_err = 0;
    int hs_cnt = 0;
    logic [63:0]  last_addr = '0;
    logic [127:0] last_data = '0;

    localparam logic [63:0] BASE = 64'h1234_5678_9ABC_DE00;

    always #2.5 clk = ~clk;

    msi_ring_poster u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msi_valid(msi_valid),
        .msi_data(msi_data), .msi_ready(msi_ready), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
        .irq_out(irq_out)
    );

    always @(posedge clk) begin
        if (mem_valid && mem_ready) begin
            hs_cnt    <= hs_cnt + 1;
            last_addr <= mem_addr;
            last_data <= mem_data;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic post(input logic [31:0] d);
        int start;
        start = hs_cnt;
        @(negedge clk);
        msi_valid = 1'b1; msi_data = d;
        while (!msi_ready) @(negedge clk);
        @(negedge clk);
        msi_valid = 1'b0;
        while (hs_cnt == start) @(negedge clk);
    endtask

    task automatic test_reset();
        logic [31:0] v;
        for (int a = 0; a < 8; a++) begin
            rreg(3'(a), v);
            chk("R1", $sformatf("reg %0d after reset", a), 128'(v), 128'h0);
        end
        chk("R1", "msi_ready", 128'(msi_ready), 128'h0);
        chk("R1", "mem_valid", 128'(mem_valid), 128'h0);
        chk("R1", "irq_out", 128'(irq_out), 128'h0);
        // R6: disabled block ignores a pending MSI
        @(negedge clk); msi_valid = 1'b1; msi_data = 32'h55;
        repeat (5) @(negedge clk);
        chk("R6", "msi_ready while disabled", 128'(msi_ready), 128'h0);
        chk("R6", "handshakes while disabled", 128'(hs_cnt), 128'h0);
        msi_valid = 1'b0;
    endtask

    task automatic test_regs();
        logic [31:0] v;
        wreg(3'h0, 32'hFFFF_FFFF);
        rreg(3'h0, v);
        chk("R2", "control readback of defined bits", 128'(v), 128'h31B);
        wreg(3'h0, 32'h0);
        wreg(3'h3, BASE[63:32]);
        wreg(3'h4, BASE[31:0]);
        rreg(3'h3, v); chk("R2", "base high", 128'(v), 128'(BASE[63:32]));
        rreg(3'h4, v); chk("R2", "base low", 128'(v), 128'(BASE[31:0]));
        wreg(3'h6, 32'h0000_1230);
        rreg(3'h6, v); chk("R2", "write offset is read-only", 128'(v), 128'h0);
        wreg(3'h1, 32'hABCD);
        rreg(3'h1, v); chk("R2", "unmapped address reads zero", 128'(v), 128'h0);
    endtask

    task automatic test_post();
        logic [31:0] v;
        int start;
        wreg(3'h0, 32'h9);
        post(32'hDEAD_BEEF);
        chk("R3", "first record address", 128'(last_addr), 128'(BASE));
        chk("R3", "first record data", last_data, 128'h0000_BEEF);
        rreg(3'h6, v); chk("R4", "write offset after one record", 128'(v), 128'h10);
        chk("R8", "irq with unread record", 128'(irq_out), 128'h1);
        wreg(3'h5, 32'h10);
        chk("R8", "irq after read offset catches up", 128'(irq_out), 128'h0);
        // stalled memory port
        mem_ready = 1'b0;
        start = hs_cnt;
        @(negedge clk); msi_valid = 1'b1; msi_data = 32'hFFFF_0042;
        while (!msi_ready) @(negedge clk);
        @(negedge clk); msi_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk("R3", "mem_valid held under stall", 128'(mem_valid), 128'h1);
            chk("R3", "address held under stall", 128'(mem_addr), 128'(BASE + 64'h10));
            @(negedge clk);
        end
        chk("R3", "no handshake under stall", 128'(hs_cnt - start), 128'h0);
        mem_ready = 1'b1;
        @(negedge clk);
        chk("R3", "one handshake after release", 128'(hs_cnt - start), 128'h1);
        chk("R3", "second record data", last_data, 128'h42);
        rreg(3'h6, v); chk("R4", "write offset after second record", 128'(v), 128'h20);
        chk("R8", "irq after second record", 128'(irq_out), 128'h1);
    endtask

    task automatic test_rd_mask();
        logic [31:0] v;
        wreg(3'h0, 32'h300);
        wreg(3'h5, 32'h0001_2345);
        rreg(3'h5, v); chk("R5", "read offset masked at 256KB", 128'(v), 128'h12340);
        wreg(3'h5, 32'hFFFF_FFFF);
        rreg(3'h5, v); chk("R5", "read offset all ones at 256KB", 128'(v), 128'h3FFF0);
        wreg(3'h0, 32'h0);
        wreg(3'h5, 32'hFFFF_FFFF);
        rreg(3'h5, v); chk("R5", "read offset all ones at 32KB", 128'(v), 128'h7FF0);
        wreg(3'h0, 32'h200);
        wreg(3'h5, 32'h0000_C010);
        rreg(3'h5, v); chk("R9", "read offset at 128KB", 128'(v), 128'hC010);
        wreg(3'h0, 32'h0);
        rreg(3'h5, v); chk("R9", "read offset re-masked at 32KB", 128'(v), 128'h4010);
    endtask

    task automatic test_disable();
        int start;
        wreg(3'h0, 32'h8);
        start = hs_cnt;
        @(negedge clk); msi_valid = 1'b1; msi_data = 32'h77;
        repeat (6) @(negedge clk);
        chk("R6", "msi_ready with enable clear", 128'(msi_ready), 128'h0);
        chk("R6", "no request with enable clear", 128'(hs_cnt - start), 128'h0);
        chk("R8", "irq with enable clear", 128'(irq_out), 128'h0);
        msi_valid = 1'b0;
    endtask

    task automatic test_full_stop();
        logic [31:0] w, v, rd;
        int start;
        rreg(3'h6, w);
        rd = (w + 32'h40) & 32'h7FF0;
        wreg(3'h5, rd);
        wreg(3'h0, 32'h1B);
        for (int k = 0; k < 3; k++) post(32'h100 + 32'(k));
        rreg(3'h6, v); chk("R7", "write offset one short of read", 128'(v), 128'((w + 32'h30) & 32'h7FF0));
        start = hs_cnt;
        @(negedge clk); msi_valid = 1'b1; msi_data = 32'h200;
        repeat (8) @(negedge clk);
        chk("R7", "msi_ready low when full", 128'(msi_ready), 128'h0);
        chk("R7", "no posting when full", 128'(hs_cnt - start), 128'h0);
        chk("R8", "irq while full", 128'(irq_out), 128'h1);
        msi_valid = 1'b0;
        wreg(3'h5, (rd + 32'h10) & 32'h7FF0);
        post(32'h201);
        rreg(3'h6, v); chk("R7", "posting resumes after space frees", 128'(v), 128'((w + 32'h40) & 32'h7FF0));
    endtask

    task automatic test_full_overwrite();
        logic [31:0] w, v, rd;
        rreg(3'h6, w);
        rd = (w + 32'h20) & 32'h7FF0;
        wreg(3'h5, rd);
        wreg(3'h0, 32'h9);
        post(32'h300);
        post(32'h301);
        rreg(3'h6, v); chk("R7", "overwrite without stop reaches read", 128'(v), 128'(rd));
        chk("R8", "irq low once offsets equal", 128'(irq_out), 128'h0);
    endtask

    task automatic test_same_cycle();
        logic [31:0] w, v, nw;
        int start;
        wreg(3'h0, 32'h9);
        rreg(3'h6, w);
        nw = (w + 32'h10) & 32'h7FF0;
        mem_ready = 1'b0;
        start = hs_cnt;
        @(negedge clk); msi_valid = 1'b1; msi_data = 32'h4444;
        while (!msi_ready) @(negedge clk);
        @(negedge clk); msi_valid = 1'b0;
        chk("R3", "pending record address", 128'(mem_addr), 128'(BASE + 64'(w)));
        @(negedge clk);
        mem_ready = 1'b1; reg_wr = 1'b1; reg_addr = 3'h5; reg_wdata = nw;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R4", "one retire on shared edge", 128'(hs_cnt - start), 128'h1);
        rreg(3'h6, v); chk("R4", "write offset on shared edge", 128'(v), 128'(nw));
        rreg(3'h5, v); chk("R5", "read offset on shared edge", 128'(v), 128'(nw));
        chk("R8", "irq low after shared edge", 128'(irq_out), 128'h0);
    endtask

    task automatic test_wrap();
        logic [31:0] w, v;
        int n;
        wreg(3'h0, 32'h1);
        rreg(3'h6, w);
        n = int'((32'h7FF0 - w) >> 4);
        for (int k = 0; k < n; k++) post(32'(k));
        rreg(3'h6, v); chk("R4", "write offset at ring end", 128'(v), 128'h7FF0);
        post(32'hAAAA);
        chk("R3", "last slot address", 128'(last_addr), 128'(BASE + 64'h7FF0));
        rreg(3'h6, v); chk("R4", "wrap to zero at 32KB", 128'(v), 128'h0);
        post(32'hBBBB);
        chk("R3", "record after wrap at base", 128'(last_addr), 128'(BASE));
        chk("R3", "record after wrap data", last_data, 128'hBBBB);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_regs();
        test_post();
        test_rd_mask();
        test_disable();
        test_full_stop();
        test_full_overwrite();
        test_same_cycle();
        test_wrap();
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule